// File: doc/BRIEF.md
# Five-Source Prioritized Interrupt Controller

This block is the interrupt front end of a small 8-bit processor core. It takes five request lines of different kinds. The first is a non-maskable line that needs a rising edge and must then stay high. The second is a maskable line that is latched on its rising edge. Two more are maskable and level-sensitive. The last is a level-sensitive external request that the enable flag alone gates. All five lines are synchronized, and the controller applies the per-source masks and the global enable. It then picks one winner by fixed priority and presents a request flag and a 16-bit service address. For the external request it raises an acknowledge indication instead of an address.

The core drives a one-cycle acknowledge strobe when it accepts the presented interrupt. It also drives a small command port that carries an accumulator byte. The four commands are enable, disable, mask write and status read. The mask write also controls a serial output bit. The status read returns a packed word holding the serial input level, the pending requests, the enable flag and the masks.

The non-maskable line is tracked by a three-state machine:
- ARMED waits for a rising edge.
- PENDING presents the request.
- SPENT waits for the line to return low after an acknowledge.

Its transitions are:
- ARMED to PENDING on a synchronized rising edge.
- PENDING to ARMED when the line drops before an acknowledge.
- PENDING to SPENT when an acknowledge grants this source.
- SPENT to ARMED when the line is low.

Top module: `intc_top`

## Requirements
- R1: After reset, irq_o and ser_out_o are 0. A status read (op_code 3) then returns 8'h07 with ser_in_i low: all three masks are set, the enable flag is clear and nothing is pending.
- R2: Fixed priority, highest first: nmi_i (vector 16'h0024), edge_i (16'h003C), lvl_hi_i (16'h0034), lvl_lo_i (16'h002C), ext_i (no vector). vector_o is 0 when no source wins.
- R3: nmi_i is presented regardless of masks and enable, starting 3 cycles after a low-to-high change. It is withdrawn if the line falls before an acknowledge. After an acknowledge it stays withdrawn until the line has been low and rises again.
- R4: A rising edge on edge_i sets a pending latch that holds after the line falls. The latch is cleared by a mask write with acc_i bit 4 set, whether or not the source is masked, and by an acknowledge that grants this source. A steady high level does not set it again.
- R5: lvl_hi_i and lvl_lo_i request only while high, unmasked and enabled. The request appears 2 cycles after the level changes.
- R6: ext_i requests only while high and enabled, with no mask. When it wins, irq_o=1, ext_ack_o=1 and vector_o=0.
- R7: op_code 0 sets the enable flag and op_code 1 clears it. An acknowledge while irq_o is high also clears it, which blocks all maskable sources but not nmi_i.
- R8: In a mask write (op_code 2), the masks load from acc_i[2:0] only when acc_i bit 3 is 1. Bit 2 masks edge_i, bit 1 masks lvl_hi_i and bit 0 masks lvl_lo_i. A mask value of 1 blocks the source.
- R9: In a mask write, ser_out_o takes acc_i bit 7 when acc_i bit 6 is 1. Otherwise ser_out_o holds its value.
- R10: A status read updates status_o on the command edge with {ser_in_i, edge latch, lvl_hi, lvl_lo, enable, mask edge, mask hi, mask lo}, from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Non-maskable request, edge plus held level |
| edge_i | input | 1 | Maskable rising-edge request |
| lvl_hi_i | input | 1 | Maskable level request, higher of the two |
| lvl_lo_i | input | 1 | Maskable level request, lower of the two |
| ext_i | input | 1 | External level request, gated only by enable |
| ack_i | input | 1 | One-cycle acknowledge of the presented interrupt |
| op_valid_i | input | 1 | Command strobe |
| op_code_i | input | 2 | 0 enable, 1 disable, 2 mask write, 3 status read |
| acc_i | input | 8 | Accumulator byte for the mask write |
| ser_in_i | input | 1 | Serial input level, captured by a status read |
| irq_o | output | 1 | Interrupt request to the core |
| vector_o | output | 16 | Service address of the winning source |
| ext_ack_o | output | 1 | External request wins; external acknowledge needed |
| status_o | output | 8 | Packed status word |
| ser_out_o | output | 1 | Serial output bit |

## Verification
Level requests reach irq_o two edges after the input changes, through the two-stage synchronizer. The edge-detected sources add one more register, for three edges in total. The bench therefore holds each input change for four cycles before it samples. Command effects and the acknowledge land on the very edge where the strobe is high. The bench samples 1 ns after that edge, so status words, masks, the enable flag and the serial bit are checked in the cycle after the strobe.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NUM_SRC  = 5;
    localparam int VEC_W    = 16;
    localparam int MASK_W   = 3;

    // source index: higher index = higher priority
    localparam int SRC_EXT  = 0;
    localparam int SRC_LO   = 1;
    localparam int SRC_HI   = 2;
    localparam int SRC_EDGE = 3;
    localparam int SRC_NMI  = 4;

    localparam logic [VEC_W-1:0] VEC_NMI  = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_EDGE = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_HI   = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_LO   = 16'h002C;

    // mask-write field positions
    localparam int MW_SDATA = 7;
    localparam int MW_SEN   = 6;
    localparam int MW_CLR   = 4;
    localparam int MW_MSE   = 3;

    typedef enum logic [1:0] {
        OP_ENABLE  = 2'd0,
        OP_DISABLE = 2'd1,
        OP_MASKWR  = 2'd2,
        OP_STATUS  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        NMI_ARMED   = 2'd0,
        NMI_PENDING = 2'd1,
        NMI_SPENT   = 2'd2
    } nmi_state_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/intc_nmi_fsm.sv
module intc_nmi_fsm
    import intc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    input  logic rise_i,
    input  logic ack_i,
    output logic pend_o
);
    nmi_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= NMI_ARMED;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pend_o  = 1'b0;
        unique case (state_q)
            NMI_ARMED: begin
                if (rise_i) state_d = NMI_PENDING;
            end
            NMI_PENDING: begin
                pend_o = 1'b1;
                if (ack_i)         state_d = NMI_SPENT;
                else if (!level_i) state_d = NMI_ARMED;
            end
            NMI_SPENT: begin
                if (!level_i) state_d = NMI_ARMED;
            end
            default: state_d = NMI_ARMED;
        endcase
    end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    always_comb begin
        grant_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) grant_o = N'(1) << i;
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             nmi_i,
    input  logic             edge_i,
    input  logic             lvl_hi_i,
    input  logic             lvl_lo_i,
    input  logic             ext_i,
    input  logic             ack_i,
    input  logic             op_valid_i,
    input  logic [1:0]       op_code_i,
    input  logic [7:0]       acc_i,
    input  logic             ser_in_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vector_o,
    output logic             ext_ack_o,
    output logic [7:0]       status_o,
    output logic             ser_out_o
);
    logic [NUM_SRC-1:0] raw, sync;
    logic [1:0]         prev_q;
    logic               nmi_rise, edge_rise, nmi_pend;
    logic               latch_q, ie_q, ser_q;
    logic [MASK_W-1:0]  masks_q;
    logic [7:0]         status_q;
    logic [NUM_SRC-1:0] req, grant;
    logic               any;
    op_e                op;
    logic               do_mw, do_ack;
    logic               unused_bit5;

    assign unused_bit5 = acc_i[5];
    assign raw = {nmi_i, edge_i, lvl_hi_i, lvl_lo_i, ext_i};

    intc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (raw),
        .q_o   (sync)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= {sync[SRC_NMI], sync[SRC_EDGE]};
    end

    assign nmi_rise  = sync[SRC_NMI]  & ~prev_q[1];
    assign edge_rise = sync[SRC_EDGE] & ~prev_q[0];

    assign op     = op_e'(op_code_i);
    assign do_mw  = op_valid_i && (op == OP_MASKWR);
    assign do_ack = ack_i && any;

    intc_nmi_fsm nmi_fsm_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .level_i(sync[SRC_NMI]),
        .rise_i (nmi_rise),
        .ack_i  (ack_i && grant[SRC_NMI]),
        .pend_o (nmi_pend)
    );

    // edge latch: a new edge wins over a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            latch_q <= 1'b0;
        else if (edge_rise)
            latch_q <= 1'b1;
        else if ((do_mw && acc_i[MW_CLR]) || (ack_i && grant[SRC_EDGE]))
            latch_q <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ie_q     <= 1'b0;
            masks_q  <= '1;
            ser_q    <= 1'b0;
            status_q <= '0;
        end else begin
            if (do_ack)
                ie_q <= 1'b0;
            else if (op_valid_i && op == OP_ENABLE)
                ie_q <= 1'b1;
            else if (op_valid_i && op == OP_DISABLE)
                ie_q <= 1'b0;
            if (do_mw && acc_i[MW_MSE])
                masks_q <= acc_i[MASK_W-1:0];
            if (do_mw && acc_i[MW_SEN])
                ser_q <= acc_i[MW_SDATA];
            if (op_valid_i && op == OP_STATUS)
                status_q <= {ser_in_i, latch_q, sync[SRC_HI], sync[SRC_LO],
                             ie_q, masks_q};
        end
    end

    assign req[SRC_NMI]  = nmi_pend;
    assign req[SRC_EDGE] = latch_q        & ie_q & ~masks_q[2];
    assign req[SRC_HI]   = sync[SRC_HI]   & ie_q & ~masks_q[1];
    assign req[SRC_LO]   = sync[SRC_LO]   & ie_q & ~masks_q[0];
    assign req[SRC_EXT]  = sync[SRC_EXT]  & ie_q;

    intc_prio #(.N(NUM_SRC)) prio_i (
        .req_i  (req),
        .grant_o(grant),
        .any_o  (any)
    );

    always_comb begin
        vector_o = '0;
        if      (grant[SRC_NMI])  vector_o = VEC_NMI;
        else if (grant[SRC_EDGE]) vector_o = VEC_EDGE;
        else if (grant[SRC_HI])   vector_o = VEC_HI;
        else if (grant[SRC_LO])   vector_o = VEC_LO;
    end

    assign irq_o     = any;
    assign ext_ack_o = grant[SRC_EXT];
    assign status_o  = status_q;
    assign ser_out_o = ser_q;
endmodule

// File: rtl/intc_chk.sv
module intc_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        ack_i,
    input logic        irq_o,
    input logic        ext_ack_o,
    input logic [15:0] vector_o,
    input logic        ie_q,
    input logic        latch_q,
    input logic        edge_rise,
    input logic [2:0]  masks_q,
    input logic        op_valid_i,
    input logic [1:0]  op_code_i,
    input logic [7:0]  acc_i,
    input logic        nmi_pend
);
    assert_ack_clears_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && irq_o) |=> !ie_q);

    assert_disabled_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ie_q && !nmi_pend) |-> !irq_o);

    assert_ext_no_vector_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_ack_o |-> (irq_o && vector_o == 16'h0000));

    assert_nmi_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nmi_pend |-> (irq_o && vector_o == 16'h0024 && !ext_ack_o));

    assert_latch_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && op_code_i == 2'd2 && acc_i[4] && !edge_rise) |=> !latch_q);

    assert_mask_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && op_code_i == 2'd2 && !acc_i[3]) |=> $stable(masks_q));
endmodule

bind intc_top intc_chk chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_i     (ack_i),
    .irq_o     (irq_o),
    .ext_ack_o (ext_ack_o),
    .vector_o  (vector_o),
    .ie_q      (ie_q),
    .latch_q   (latch_q),
    .edge_rise (edge_rise),
    .masks_q   (masks_q),
    .op_valid_i(op_valid_i),
    .op_code_i (op_code_i),
    .acc_i     (acc_i),
    .nmi_pend  (nmi_pend)
);

// File: tb/intc_top_tb_top.sv
`timescale 1ns/1ps
module intc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi = 0, edg = 0, lhi = 0, llo = 0, ext = 0, ack = 0;
    logic        opv = 0;
    logic [1:0]  opc = 0;
    logic [7:0]  acc = 0;
    logic        sin = 0;
    logic        irq, eack, sout;
    logic [15:0] vec;
    logic [7:0]  stat;
    int          checks = 0, fails = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    intc_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .edge_i(edg),
        .lvl_hi_i(lhi), .lvl_lo_i(llo), .ext_i(ext), .ack_i(ack),
        .op_valid_i(opv), .op_code_i(opc), .acc_i(acc), .ser_in_i(sin),
        .irq_o(irq), .vector_o(vec), .ext_ack_o(eack),
        .status_o(stat), .ser_out_o(sout)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cmd(input logic [1:0] c, input logic [7:0] a);
        opv = 1; opc = c; acc = a;
        tick(1);
        opv = 0; acc = 0;
    endtask

    task automatic pulse_ack();
        ack = 1;
        tick(1);
        ack = 0;
    endtask

    task automatic t_reset();
        chk("R1", "irq", {15'd0, irq}, 16'd0);
        chk("R1", "ser_out", {15'd0, sout}, 16'd0);
        cmd(2'd3, 8'h00);
        chk("R1", "status", {8'd0, stat}, 16'h0007);
    endtask

    task automatic t_nmi();
        nmi = 1; tick(4);
        chk("R3", "nmi irq while masked/disabled", {15'd0, irq}, 16'd1);
        chk("R3", "nmi vector", vec, 16'h0024);
        nmi = 0; tick(4);
        chk("R3", "withdrawn on early drop", {15'd0, irq}, 16'd0);
        nmi = 1; tick(4);
        pulse_ack(); tick(2);
        chk("R3", "no request after ack while high", {15'd0, irq}, 16'd0);
        nmi = 0; tick(4);
        nmi = 1; tick(4);
        chk("R3", "re-armed after low", {15'd0, irq}, 16'd1);
        pulse_ack();
        nmi = 0; tick(4);
    endtask

    task automatic t_priority();
        cmd(2'd2, 8'h08);
        cmd(2'd0, 8'h00);
        llo = 1; tick(4);
        chk("R5", "lo vector", vec, 16'h002C);
        lhi = 1; tick(4);
        chk("R2", "hi over lo", vec, 16'h0034);
        edg = 1; ext = 1; tick(4);
        chk("R2", "edge over hi", vec, 16'h003C);
        nmi = 1; tick(4);
        chk("R2", "nmi over all", vec, 16'h0024);
        nmi = 0; tick(4);
        chk("R4", "edge latch holds", vec, 16'h003C);
        pulse_ack();
        chk("R7", "ack clears enable", {15'd0, irq}, 16'd0);
        cmd(2'd3, 8'h00);
        chk("R10", "status after ack", {8'd0, stat}, 16'h0030);
        cmd(2'd0, 8'h00);
        chk("R4", "latch cleared by ack", vec, 16'h0034);
    endtask

    task automatic t_masks();
        cmd(2'd2, 8'h0A);
        chk("R8", "hi masked", vec, 16'h002C);
        cmd(2'd2, 8'h07);
        chk("R8", "mask write without enable bit ignored", vec, 16'h002C);
        cmd(2'd2, 8'h09);
        chk("R8", "lo masked hi unmasked", vec, 16'h0034);
    endtask

    task automatic t_edge_clear();
        cmd(2'd2, 8'h0C);
        lhi = 0; llo = 0; ext = 0; edg = 0; tick(4);
        edg = 1; tick(4);
        chk("R4", "masked edge gives no irq", {15'd0, irq}, 16'd0);
        cmd(2'd3, 8'h00);
        chk("R4", "latch set while masked", {15'd0, stat[6]}, 16'd1);
        cmd(2'd2, 8'h10);
        cmd(2'd3, 8'h00);
        chk("R4", "latch cleared by mask write", {15'd0, stat[6]}, 16'd0);
        cmd(2'd2, 8'h08); tick(3);
        chk("R4", "steady high no re-latch", {15'd0, irq}, 16'd0);
        edg = 0; tick(4);
    endtask

    task automatic t_ext();
        ext = 1; tick(4);
        chk("R6", "ext irq", {15'd0, irq}, 16'd1);
        chk("R6", "ext ack flag", {15'd0, eack}, 16'd1);
        chk("R6", "ext vector zero", vec, 16'h0000);
        cmd(2'd1, 8'h00);
        chk("R7", "disable blocks ext", {15'd0, irq}, 16'd0);
        cmd(2'd0, 8'h00);
        chk("R7", "enable restores ext", {15'd0, irq}, 16'd1);
        pulse_ack();
        chk("R7", "ack clears enable (ext)", {15'd0, irq}, 16'd0);
        ext = 0; tick(4);
    endtask

    task automatic t_serial();
        cmd(2'd2, 8'hC0);
        chk("R9", "ser out set", {15'd0, sout}, 16'd1);
        cmd(2'd2, 8'h80);
        chk("R9", "ser out held", {15'd0, sout}, 16'd1);
        cmd(2'd2, 8'h40);
        chk("R9", "ser out cleared", {15'd0, sout}, 16'd0);
        sin = 1;
        cmd(2'd3, 8'h00);
        chk("R10", "ser in in status", {15'd0, stat[7]}, 16'd1);
        chk("R10", "status word", {8'd0, stat}, 16'h0080);
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(2);
        t_reset();
        t_nmi();
        t_priority();
        t_masks();
        t_edge_clear();
        t_ext();
        t_serial();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule